// File: doc/BRIEF.md
# RC4 Byte Stream Cipher with Context Save and Restore

This block encrypts or decrypts a byte stream with the RC4 keystream. A host sets a mode, a key and a key length through simple register strobes, then pulses `start`. In keyed mode the engine fills its 256-entry substitution table with the identity, runs the key schedule, and then XORs each byte arriving on the input stream port with the next keystream byte. The result goes to the output stream port. Both stream ports use a valid/ready handshake. A message ends with the byte flagged `in_last`.

The complete cipher state is 259 bytes: the table, the two indices and one pad byte. It can be brought back in, either by register writes or as a 259-byte burst on the input stream, so a message can resume without redoing the key schedule. It can also be sent out after a message as a 259-byte burst on the output stream. Misuse of the mode register and a bad key length raise sticky error flags. These are cleared by reset or by `reinit`.

States: IDLE (waits for `start`; accepts context register writes), FILL (identity fill, 256 cycles), KRD_I / KRD_J / KWR_J (one key-schedule step), CTX_IN (259-byte context burst in), WAIT (waits for an input byte and a free output slot), PRD_I / PRD_J / PWR_J / POUT (one keystream step), FLUSH (waits for the last output byte to be taken), DUMP (259-byte context burst out).

Transitions:
- IDLE goes to FILL on `start` in keyed mode with a valid key length.
- IDLE goes to CTX_IN on `start` with resume and stream-source set.
- IDLE goes to WAIT on `start` with resume set and stream-source clear.
- FILL goes to KRD_I after table entry 255 is written.
- KRD_I goes to KRD_J, KRD_J goes to KWR_J, and KWR_J goes back to KRD_I, or to WAIT after index 255.
- CTX_IN goes to WAIT after byte 258.
- WAIT goes to PRD_I.
- PRD_I, PRD_J, PWR_J and POUT follow in order. POUT goes back to WAIT, or to FLUSH on the last byte.
- FLUSH goes to DUMP when dump is set, otherwise to IDLE.
- DUMP goes to IDLE after 259 bytes.
- `reinit` takes any state to IDLE.

Top module: `rc4_ctx_engine`

## Requirements
- R1: After reset or a `reinit` pulse: `mode_rdata` reads 0, `busy` and `out_valid` are low, `in_ready` is low, and all three error flags are low.
- R2: Mode bit 0 is resume (skip the key schedule), bit 1 is dump, and bit 2 is stream-source. A mode write that sets any of bits 7..3 raises `err_data` and leaves the mode unchanged.
- R3: A mode write while `busy` is high raises `err_ctx` and leaves the mode unchanged.
- R4: A `start` with resume clear and a key length of 0 or above KEY_MAX raises `err_ksize`, and the engine stays idle.
- R5: With resume clear, the output equals standard RC4 for the loaded key. Key "Key" (4B 65 79) on "Plaintext" gives BB F3 16 E8 D9 40 AF 0A D3.
- R6: The key schedule uses key bytes 0 to length-1 cyclically. Key register bytes at or above the length have no effect.
- R7: Table and indices persist between messages. A message started with resume set and stream-source clear continues the keystream where the previous message stopped.
- R8: In IDLE, `ctx_we` with `ctx_idx` 0..255 writes table entry `ctx_idx`, 256 writes index i, and 257 writes index j. Index 258 is ignored.
- R9: With resume and stream-source set, `start` takes exactly 259 input bytes as context: table entries 0..255, then i, then j, then one discarded byte. The message bytes follow.
- R10: With dump set, once the last output byte is taken, 259 bytes leave on the output stream: table 0..255, then i, then j, then 0. This works together with resume.
- R11: While `out_valid` is high and `out_ready` low, `out_valid` and `out_data` hold.
- R12: `busy` rises on the edge that accepts `start` and falls when the message, including any dump, completes. `done` pulses for one cycle at that point.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reinit | input | 1 | Synchronous re-initialise: mode, errors and sequencer cleared |
| start | input | 1 | Begin a message |
| mode_we | input | 1 | Mode write strobe |
| mode_wdata | input | 8 | Mode write value |
| mode_rdata | output | 3 | Current mode bits |
| key_we | input | 1 | Key byte write strobe |
| key_waddr | input | 4 | Key byte index |
| key_wdata | input | 8 | Key byte value |
| ksize_we | input | 1 | Key length write strobe |
| ksize_wdata | input | 5 | Key length in bytes |
| ctx_we | input | 1 | Context byte write strobe (idle only) |
| ctx_idx | input | 9 | Context byte position 0..258 |
| ctx_wdata | input | 8 | Context byte value |
| in_valid | input | 1 | Input byte valid |
| in_data | input | 8 | Input byte |
| in_last | input | 1 | Input byte ends the message |
| in_ready | output | 1 | Input byte accepted this cycle |
| out_valid | output | 1 | Output byte valid |
| out_data | output | 8 | Output byte |
| out_ready | input | 1 | Output byte taken |
| busy | output | 1 | Message in progress |
| done | output | 1 | One-cycle pulse at message completion |
| err_data | output | 1 | Reserved mode bit written |
| err_ctx | output | 1 | Mode written while busy |
| err_ksize | output | 1 | Bad key length at start |

## Verification
The bench builds the block with its default KEY_MAX of 16. The 5-bit key-length field can then carry both failing boundary values, 0 and 17. A 3-byte and a 5-byte key exercise cyclic key reuse, with junk loaded in the unused key bytes. The table size is fixed at 256, so every run covers the full key schedule, a register-loaded context with nonzero indices and a write to the ignored position 258, and a stream-loaded context whose pad byte is nonzero. Dumps are compared byte for byte against a bench model, including the trailing zero.

// File: rtl/rc4_pkg.sv
package rc4_pkg;
    localparam int SBOX_N  = 256;
    localparam int SB_AW   = $clog2(SBOX_N);
    localparam int CTX_LEN = SBOX_N + 3;
    localparam int CNT_W   = $clog2(CTX_LEN + 1);
    localparam int MODE_W  = 3;
    localparam int BIT_PP  = 0;
    localparam int BIT_DC  = 1;
    localparam int BIT_CS  = 2;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_FILL,
        ST_KRD_I,
        ST_KRD_J,
        ST_KWR_J,
        ST_CTX_IN,
        ST_WAIT,
        ST_PRD_I,
        ST_PRD_J,
        ST_PWR_J,
        ST_POUT,
        ST_FLUSH,
        ST_DUMP
    } rc4_state_t;
endpackage

// File: rtl/rc4_sbox.sv
module rc4_sbox #(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata
);
    localparam int DEPTH = 1 << AW;

    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/rc4_mode_regs.sv
module rc4_mode_regs
    import rc4_pkg::*;
#(
    parameter int KEY_MAX = 16,
    parameter int KIDX_W  = $clog2(KEY_MAX),
    parameter int KSZ_W   = $clog2(KEY_MAX + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reinit,
    input  logic              busy,
    input  logic              start,
    input  logic              mode_we,
    input  logic [7:0]        mode_wdata,
    input  logic              key_we,
    input  logic [KIDX_W-1:0] key_waddr,
    input  logic [7:0]        key_wdata,
    input  logic              ksz_we,
    input  logic [KSZ_W-1:0]  ksz_wdata,
    input  logic [KIDX_W-1:0] key_rd_idx,
    output logic [7:0]        key_byte,
    output logic [KSZ_W-1:0]  ksize_q,
    output logic              ksize_ok,
    output logic [MODE_W-1:0] mode_q,
    output logic              err_data,
    output logic              err_ctx,
    output logic              err_ksize
);
    localparam logic [7:0] LEGAL_MASK = 8'((1 << MODE_W) - 1);

    logic [7:0] key_q [KEY_MAX];
    logic       res_hit;

    assign res_hit  = |(mode_wdata & ~LEGAL_MASK);
    assign ksize_ok = (ksize_q != '0) && (int'(ksize_q) <= KEY_MAX);
    assign key_byte = key_q[key_rd_idx];

    always_ff @(posedge clk) begin
        for (int k = 0; k < KEY_MAX; k++) begin
            if (key_we && (int'(key_waddr) == k)) key_q[k] <= key_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q    <= '0;
            ksize_q   <= '0;
            err_data  <= 1'b0;
            err_ctx   <= 1'b0;
            err_ksize <= 1'b0;
        end else if (reinit) begin
            mode_q    <= '0;
            err_data  <= 1'b0;
            err_ctx   <= 1'b0;
            err_ksize <= 1'b0;
        end else begin
            if (mode_we) begin
                if (busy)    err_ctx  <= 1'b1;
                if (res_hit) err_data <= 1'b1;
                if (!busy && !res_hit) mode_q <= mode_wdata[MODE_W-1:0];
            end
            if (start && !busy && !mode_q[BIT_PP] && !ksize_ok) err_ksize <= 1'b1;
            if (ksz_we) ksize_q <= ksz_wdata;
        end
    end

    // R1: re-initialise clears mode and all error flags
    a_r1_reinit_clear: assert property (@(posedge clk) disable iff (!rst_n)
        reinit |=> (mode_q == '0) && !err_data && !err_ctx && !err_ksize);

    // R2: reserved bit write flags a data error and keeps the mode
    a_r2_reserved_err: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_we && res_hit && !reinit) |=> err_data && $stable(mode_q));

    // R3: mode write during a message flags a context error and keeps the mode
    a_r3_busy_write: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_we && busy && !reinit) |=> err_ctx && $stable(mode_q));
endmodule

// File: rtl/rc4_core_fsm.sv
module rc4_core_fsm
    import rc4_pkg::*;
#(
    parameter int KEY_MAX = 16,
    parameter int KIDX_W  = $clog2(KEY_MAX),
    parameter int KSZ_W   = $clog2(KEY_MAX + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reinit,
    input  logic              start,
    input  logic              mode_pp,
    input  logic              mode_dc,
    input  logic              mode_cs,
    input  logic              ksize_ok,
    input  logic [KSZ_W-1:0]  ksize,
    input  logic [7:0]        key_byte,
    output logic [KIDX_W-1:0] key_idx,
    input  logic              ctx_we,
    input  logic [CNT_W-1:0]  ctx_idx,
    input  logic [7:0]        ctx_wdata,
    input  logic              in_valid,
    input  logic [7:0]        in_data,
    input  logic              in_last,
    output logic              in_ready,
    output logic              out_valid,
    output logic [7:0]        out_data,
    input  logic              out_ready,
    output logic              busy,
    output logic              done,
    output logic [SB_AW-1:0]  sb_raddr,
    input  logic [7:0]        sb_rdata,
    output logic              sb_we,
    output logic [SB_AW-1:0]  sb_waddr,
    output logic [7:0]        sb_wdata
);
    rc4_state_t state, state_n;

    logic [7:0]       i_q, j_q, si_q, sj_q;
    logic [CNT_W-1:0] cnt_q;
    logic [7:0]       ctx_byte;
    logic             out_fire;
    logic             out_free;

    assign out_fire = out_valid && out_ready;
    assign out_free = !out_valid || out_fire;
    assign busy     = (state != ST_IDLE);
    assign in_ready = (state == ST_CTX_IN) || (state == ST_POUT);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      state <= ST_IDLE;
        else if (reinit) state <= ST_IDLE;
        else             state <= state_n;
    end

    // next state and table port control
    always_comb begin
        state_n  = state;
        sb_raddr = i_q;
        sb_we    = 1'b0;
        sb_waddr = i_q;
        sb_wdata = 8'h00;
        unique case (state)
            ST_IDLE: begin
                if (ctx_we && (int'(ctx_idx) < SBOX_N)) begin
                    sb_we    = 1'b1;
                    sb_waddr = ctx_idx[SB_AW-1:0];
                    sb_wdata = ctx_wdata;
                end
                if (start) begin
                    if (mode_pp)       state_n = mode_cs ? ST_CTX_IN : ST_WAIT;
                    else if (ksize_ok) state_n = ST_FILL;
                end
            end
            ST_FILL: begin
                sb_we    = 1'b1;
                sb_waddr = cnt_q[SB_AW-1:0];
                sb_wdata = cnt_q[7:0];
                if (cnt_q[SB_AW-1:0] == '1) state_n = ST_KRD_I;
            end
            ST_KRD_I: begin
                sb_raddr = i_q;
                state_n  = ST_KRD_J;
            end
            ST_KRD_J: begin
                sb_raddr = j_q;
                sb_we    = 1'b1;
                sb_waddr = i_q;
                sb_wdata = sb_rdata;
                state_n  = ST_KWR_J;
            end
            ST_KWR_J: begin
                sb_we    = 1'b1;
                sb_waddr = j_q;
                sb_wdata = si_q;
                state_n  = (i_q == 8'hFF) ? ST_WAIT : ST_KRD_I;
            end
            ST_CTX_IN: begin
                if (in_valid) begin
                    if (int'(cnt_q) < SBOX_N) begin
                        sb_we    = 1'b1;
                        sb_waddr = cnt_q[SB_AW-1:0];
                        sb_wdata = in_data;
                    end
                    if (int'(cnt_q) == CTX_LEN - 1) state_n = ST_WAIT;
                end
            end
            ST_WAIT: begin
                if (in_valid && !out_valid) state_n = ST_PRD_I;
            end
            ST_PRD_I: begin
                sb_raddr = i_q + 8'd1;
                state_n  = ST_PRD_J;
            end
            ST_PRD_J: begin
                sb_raddr = j_q;
                sb_we    = 1'b1;
                sb_waddr = i_q;
                sb_wdata = sb_rdata;
                state_n  = ST_PWR_J;
            end
            ST_PWR_J: begin
                sb_we    = 1'b1;
                sb_waddr = j_q;
                sb_wdata = si_q;
                state_n  = ST_POUT;
            end
            ST_POUT: begin
                sb_raddr = si_q + sj_q;
                state_n  = in_last ? ST_FLUSH : ST_WAIT;
            end
            ST_FLUSH: begin
                if (out_free) state_n = mode_dc ? ST_DUMP : ST_IDLE;
            end
            ST_DUMP: begin
                sb_raddr = cnt_q[SB_AW-1:0];
                if (out_free && (int'(cnt_q) == CTX_LEN)) state_n = ST_IDLE;
            end
        endcase
    end

    always_comb begin
        if (int'(cnt_q) < SBOX_N)       ctx_byte = sb_rdata;
        else if (int'(cnt_q) == SBOX_N) ctx_byte = i_q;
        else if (int'(cnt_q) == SBOX_N + 1) ctx_byte = j_q;
        else                            ctx_byte = 8'h00;
    end

    // datapath and output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            i_q       <= '0;
            j_q       <= '0;
            si_q      <= '0;
            sj_q      <= '0;
            cnt_q     <= '0;
            key_idx   <= '0;
            out_valid <= 1'b0;
            out_data  <= '0;
            done      <= 1'b0;
        end else if (reinit) begin
            cnt_q     <= '0;
            out_valid <= 1'b0;
            done      <= 1'b0;
        end else begin
            done <= busy && (state_n == ST_IDLE);
            if (out_fire) out_valid <= 1'b0;
            case (state)
                ST_IDLE: begin
                    cnt_q <= '0;
                    if (ctx_we && (int'(ctx_idx) == SBOX_N))     i_q <= ctx_wdata;
                    if (ctx_we && (int'(ctx_idx) == SBOX_N + 1)) j_q <= ctx_wdata;
                end
                ST_FILL: begin
                    cnt_q <= cnt_q + 1'b1;
                    if (cnt_q[SB_AW-1:0] == '1) begin
                        i_q     <= '0;
                        j_q     <= '0;
                        key_idx <= '0;
                    end
                end
                ST_KRD_I: begin
                    si_q <= sb_rdata;
                    j_q  <= j_q + sb_rdata + key_byte;
                end
                ST_KWR_J: begin
                    i_q <= i_q + 8'd1;
                    if (KSZ_W'(key_idx) + KSZ_W'(1) == ksize) key_idx <= '0;
                    else                                     key_idx <= key_idx + 1'b1;
                    if (i_q == 8'hFF) j_q <= '0;
                end
                ST_CTX_IN: begin
                    if (in_valid) begin
                        cnt_q <= cnt_q + 1'b1;
                        if (int'(cnt_q) == SBOX_N)     i_q <= in_data;
                        if (int'(cnt_q) == SBOX_N + 1) j_q <= in_data;
                    end
                end
                ST_PRD_I: begin
                    si_q <= sb_rdata;
                    i_q  <= i_q + 8'd1;
                    j_q  <= j_q + sb_rdata;
                end
                ST_PRD_J: sj_q <= sb_rdata;
                ST_POUT: begin
                    out_data  <= in_data ^ sb_rdata;
                    out_valid <= 1'b1;
                    cnt_q     <= '0;
                end
                ST_DUMP: begin
                    if (out_free && (int'(cnt_q) != CTX_LEN)) begin
                        out_data  <= ctx_byte;
                        out_valid <= 1'b1;
                        cnt_q     <= cnt_q + 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    // R11: an offered output byte holds until taken
    a_r11_out_hold: assert property (@(posedge clk) disable iff (!rst_n || reinit)
        (out_valid && !out_ready) |=> out_valid && $stable(out_data));

    // R4: a bad key length keeps the sequencer idle
    a_r4_ksize_block: assert property (@(posedge clk) disable iff (!rst_n || reinit)
        (state == ST_IDLE && start && !mode_pp && !ksize_ok) |=> (state == ST_IDLE));

    // R12: an accepted start makes the engine busy on the next cycle
    a_r12_busy_rise: assert property (@(posedge clk) disable iff (!rst_n || reinit)
        (state == ST_IDLE && start && (mode_pp || ksize_ok)) |=> busy);

    // R12: done is a single-cycle pulse
    a_r12_done_pulse: assert property (@(posedge clk) disable iff (!rst_n || reinit)
        done |=> !done);

    // R9: context burst bytes are taken only while the counter is in range
    a_r9_ctx_count: assert property (@(posedge clk) disable iff (!rst_n || reinit)
        (state == ST_CTX_IN) |-> (int'(cnt_q) < CTX_LEN));
endmodule

// File: rtl/rc4_ctx_engine.sv
module rc4_ctx_engine
    import rc4_pkg::*;
#(
    parameter int KEY_MAX = 16,
    parameter int KIDX_W  = $clog2(KEY_MAX),
    parameter int KSZ_W   = $clog2(KEY_MAX + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reinit,
    input  logic              start,
    input  logic              mode_we,
    input  logic [7:0]        mode_wdata,
    output logic [MODE_W-1:0] mode_rdata,
    input  logic              key_we,
    input  logic [KIDX_W-1:0] key_waddr,
    input  logic [7:0]        key_wdata,
    input  logic              ksize_we,
    input  logic [KSZ_W-1:0]  ksize_wdata,
    input  logic              ctx_we,
    input  logic [CNT_W-1:0]  ctx_idx,
    input  logic [7:0]        ctx_wdata,
    input  logic              in_valid,
    input  logic [7:0]        in_data,
    input  logic              in_last,
    output logic              in_ready,
    output logic              out_valid,
    output logic [7:0]        out_data,
    input  logic              out_ready,
    output logic              busy,
    output logic              done,
    output logic              err_data,
    output logic              err_ctx,
    output logic              err_ksize
);
    logic [7:0]        key_byte;
    logic [KIDX_W-1:0] key_idx;
    logic [KSZ_W-1:0]  ksize_q;
    logic              ksize_ok;
    logic [MODE_W-1:0] mode_q;
    logic [SB_AW-1:0]  sb_raddr, sb_waddr;
    logic [7:0]        sb_rdata, sb_wdata;
    logic              sb_we;

    assign mode_rdata = mode_q;

    rc4_mode_regs #(.KEY_MAX(KEY_MAX), .KIDX_W(KIDX_W), .KSZ_W(KSZ_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .reinit(reinit), .busy(busy), .start(start),
        .mode_we(mode_we), .mode_wdata(mode_wdata),
        .key_we(key_we), .key_waddr(key_waddr), .key_wdata(key_wdata),
        .ksz_we(ksize_we), .ksz_wdata(ksize_wdata),
        .key_rd_idx(key_idx), .key_byte(key_byte),
        .ksize_q(ksize_q), .ksize_ok(ksize_ok), .mode_q(mode_q),
        .err_data(err_data), .err_ctx(err_ctx), .err_ksize(err_ksize)
    );

    rc4_core_fsm #(.KEY_MAX(KEY_MAX), .KIDX_W(KIDX_W), .KSZ_W(KSZ_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .reinit(reinit), .start(start),
        .mode_pp(mode_q[BIT_PP]), .mode_dc(mode_q[BIT_DC]), .mode_cs(mode_q[BIT_CS]),
        .ksize_ok(ksize_ok), .ksize(ksize_q), .key_byte(key_byte), .key_idx(key_idx),
        .ctx_we(ctx_we), .ctx_idx(ctx_idx), .ctx_wdata(ctx_wdata),
        .in_valid(in_valid), .in_data(in_data), .in_last(in_last), .in_ready(in_ready),
        .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready),
        .busy(busy), .done(done),
        .sb_raddr(sb_raddr), .sb_rdata(sb_rdata), .sb_we(sb_we),
        .sb_waddr(sb_waddr), .sb_wdata(sb_wdata)
    );

    rc4_sbox #(.AW(SB_AW)) u_sbox (
        .clk(clk), .raddr(sb_raddr), .rdata(sb_rdata),
        .we(sb_we), .waddr(sb_waddr), .wdata(sb_wdata)
    );
endmodule

// File: tb/rc4_ctx_engine_tb.sv
`timescale 1ns/1ps
module rc4_ctx_engine_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reinit = 0, start = 0, mode_we = 0, key_we = 0, ksize_we = 0, ctx_we = 0;
    logic [7:0] mode_wdata = 0, key_wdata = 0, ctx_wdata = 0, in_data = 0;
    logic [3:0] key_waddr = 0;
    logic [4:0] ksize_wdata = 0;
    logic [8:0] ctx_idx = 0;
    logic       in_valid = 0, in_last = 0, out_ready = 0;
    logic [2:0] mode_rdata;
    logic       in_ready, out_valid, busy, done, err_data, err_ctx, err_ksize;
    logic [7:0] out_data;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    logic [7:0] ms [256];
    logic [7:0] mi, mj;
    logic [7:0] keybuf [16];

    always #2 clk = ~clk;

    rc4_ctx_engine u_dut (
        .clk(clk), .rst_n(rst_n), .reinit(reinit), .start(start),
        .mode_we(mode_we), .mode_wdata(mode_wdata), .mode_rdata(mode_rdata),
        .key_we(key_we), .key_waddr(key_waddr), .key_wdata(key_wdata),
        .ksize_we(ksize_we), .ksize_wdata(ksize_wdata),
        .ctx_we(ctx_we), .ctx_idx(ctx_idx), .ctx_wdata(ctx_wdata),
        .in_valid(in_valid), .in_data(in_data), .in_last(in_last), .in_ready(in_ready),
        .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready),
        .busy(busy), .done(done),
        .err_data(err_data), .err_ctx(err_ctx), .err_ksize(err_ksize)
    );

    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            errors++;
            $display("FAIL watchdog: run did not finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // ---------- reference model ----------
    task automatic m_ksa(input int n);
        logic [7:0] jj, t;
        for (int x = 0; x < 256; x++) ms[x] = x[7:0];
        jj = 0;
        for (int x = 0; x < 256; x++) begin
            jj = jj + ms[x] + keybuf[x % n];
            t = ms[x]; ms[x] = ms[jj]; ms[jj] = t;
        end
        mi = 0; mj = 0;
    endtask

    task automatic m_step(input logic [7:0] d, output logic [7:0] r);
        logic [7:0] t, k;
        mi = mi + 8'd1;
        mj = mj + ms[mi];
        t = ms[mi]; ms[mi] = ms[mj]; ms[mj] = t;
        k = ms[mi] + ms[mj];
        r = d ^ ms[k];
    endtask

    function automatic logic [7:0] m_ctx(input int p);
        if (p < 256) return ms[p];
        if (p == 256) return mi;
        if (p == 257) return mj;
        return 8'h00;
    endfunction

    // ---------- bus tasks ----------
    task automatic wr_mode(input logic [7:0] v);
        @(negedge clk); mode_we = 1; mode_wdata = v;
        @(negedge clk); mode_we = 0;
    endtask

    task automatic wr_key(input int n, input int ks);
        for (int x = 0; x < n; x++) begin
            @(negedge clk); key_we = 1; key_waddr = x[3:0]; key_wdata = keybuf[x];
        end
        @(negedge clk); key_we = 0; ksize_we = 1; ksize_wdata = ks[4:0];
        @(negedge clk); ksize_we = 0;
    endtask

    task automatic go();
        @(negedge clk); start = 1;
        @(negedge clk); start = 0;
    endtask

    task automatic do_reinit();
        @(negedge clk); reinit = 1;
        @(negedge clk); reinit = 0;
    endtask

    task automatic push(input logic [7:0] d, input bit last);
        @(negedge clk); in_valid = 1; in_data = d; in_last = last;
        while (!in_ready) @(negedge clk);
        @(negedge clk); in_valid = 0; in_last = 0;
    endtask

    task automatic pull(output logic [7:0] r);
        while (!out_valid) @(negedge clk);
        r = out_data; out_ready = 1;
        @(negedge clk); out_ready = 0;
    endtask

    task automatic run_msg(input int n, input logic [7:0] seed, input string req);
        logic [7:0] exp, got, d;
        for (int x = 0; x < n; x++) begin
            d = seed + 8'(x * 37);
            m_step(d, exp);
            push(d, x == n - 1);
            pull(got);
            chk(got == exp, req, got, exp);
        end
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
    endtask

    // ---------- scenarios ----------
    task automatic t_reset();
        chk(mode_rdata == 0 && !busy && !out_valid && !in_ready, "R1 reset outputs",
            {mode_rdata, busy, out_valid, in_ready}, 0);
        chk(!err_data && !err_ctx && !err_ksize, "R1 reset errors",
            {err_data, err_ctx, err_ksize}, 0);
    endtask

    task automatic t_known();
        logic [7:0] pt [9] = '{8'h50, 8'h6C, 8'h61, 8'h69, 8'h6E, 8'h74, 8'h65, 8'h78, 8'h74};
        logic [7:0] ct [9] = '{8'hBB, 8'hF3, 8'h16, 8'hE8, 8'hD9, 8'h40, 8'hAF, 8'h0A, 8'hD3};
        logic [7:0] got, exp;
        bit seen;
        keybuf[0] = 8'h4B; keybuf[1] = 8'h65; keybuf[2] = 8'h79;
        wr_key(3, 3);
        wr_mode(8'h00);
        m_ksa(3);
        go();
        chk(busy, "R12 busy after start", busy, 1);
        for (int x = 0; x < 9; x++) begin
            m_step(pt[x], exp);
            push(pt[x], x == 8);
            pull(got);
            chk(got == ct[x] && got == exp, "R5 known vector", got, ct[x]);
        end
        seen = 0;
        for (int w = 0; w < 10; w++) begin
            if (done) seen = 1;
            @(negedge clk);
        end
        chk(seen, "R12 done pulse", seen, 1);
        chk(!busy, "R12 busy falls", busy, 0);
    endtask

    task automatic t_resume();
        logic [7:0] got;
        logic [7:0] held;
        wr_mode(8'h01);
        go();
        run_msg(3, 8'h10, "R7 resume continues keystream");
        wait_idle();
        // R11 hold check on a one-byte resumed message
        go();
        begin
            logic [7:0] exp;
            m_step(8'h5A, exp);
            push(8'h5A, 1);
            held = out_data;
            for (int w = 0; w < 5; w++) @(negedge clk);
            chk(out_valid && out_data == held, "R11 output holds", out_data, held);
            pull(got);
            chk(got == exp, "R11 held byte value", got, exp);
        end
        wait_idle();
    endtask

    task automatic t_keycycle();
        for (int x = 0; x < 16; x++) keybuf[x] = 8'(8'hC3 ^ (x * 29));
        wr_key(16, 5);
        for (int x = 5; x < 16; x++) keybuf[x] = 8'h00;
        wr_mode(8'h00);
        m_ksa(5);
        go();
        run_msg(6, 8'h21, "R6 cyclic key of length 5");
        wait_idle();
    endtask

    task automatic t_ksize_err();
        do_reinit();
        wr_key(0, 0);
        go();
        chk(!busy && err_ksize, "R4 key length 0", {busy, err_ksize}, 1);
        do_reinit();
        chk(!err_ksize, "R1 reinit clears ksize error", err_ksize, 0);
        wr_key(0, 17);
        go();
        chk(!busy && err_ksize, "R4 key length 17", {busy, err_ksize}, 1);
        do_reinit();
    endtask

    task automatic t_reserved();
        wr_mode(8'h11);
        chk(err_data && mode_rdata == 0, "R2 reserved bit", {err_data, mode_rdata}, 8);
        wr_mode(8'h07);
        chk(mode_rdata == 3'h7, "R2 legal mode bits", mode_rdata, 7);
        do_reinit();
        chk(mode_rdata == 0 && !err_data, "R1 reinit clears mode", {err_data, mode_rdata}, 0);
    endtask

    task automatic t_ctx_err();
        keybuf[0] = 8'h01; keybuf[1] = 8'h02; keybuf[2] = 8'h03; keybuf[3] = 8'h04;
        wr_key(4, 4);
        wr_mode(8'h00);
        m_ksa(4);
        go();
        wr_mode(8'h01);
        chk(err_ctx && mode_rdata == 0, "R3 mode write while busy", {err_ctx, mode_rdata}, 8);
        run_msg(1, 8'h33, "R3 message after rejected write");
        wait_idle();
        do_reinit();
    endtask

    task automatic t_reg_ctx();
        logic [7:0] got;
        for (int x = 0; x < 256; x++) ms[x] = 8'(255 - x);
        mi = 8'd5; mj = 8'd7;
        for (int p = 0; p < 259; p++) begin
            @(negedge clk); ctx_we = 1; ctx_idx = p[8:0];
            ctx_wdata = (p == 258) ? 8'hEE : m_ctx(p);
        end
        @(negedge clk); ctx_we = 0;
        wr_mode(8'h03);
        go();
        run_msg(3, 8'h44, "R8 register-loaded context");
        for (int p = 0; p < 259; p++) begin
            pull(got);
            chk(got == m_ctx(p), (p >= 256) ? "R10 dump tail" : "R10 dump table",
                got, m_ctx(p));
        end
        wait_idle();
        chk(!busy && !out_valid, "R10 idle after dump", {busy, out_valid}, 0);
    endtask

    task automatic t_fifo_ctx();
        logic [7:0] d;
        for (int x = 0; x < 6; x++) keybuf[x] = 8'(8'h53 + x * 11);
        m_ksa(6);
        for (int x = 0; x < 4; x++) m_step(8'h00, d);
        do_reinit();
        wr_mode(8'h05);
        go();
        for (int p = 0; p < 259; p++) push((p == 258) ? 8'hA5 : m_ctx(p), 0);
        run_msg(5, 8'h66, "R9 stream-loaded context");
        wait_idle();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_known();
        t_resume();
        t_keycycle();
        t_ksize_err();
        t_reserved();
        t_ctx_err();
        t_reg_ctx();
        t_fifo_ctx();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule